// File: doc/BRIEF.md
# USB OTG Status Interrupt Latch

This block gathers eight live status lines from a USB On-The-Go transceiver (cable and line-state detectors) and turns chosen transitions on them into an interrupt for the host processor. Each line is first brought into the local clock domain through a two-flop synchroniser. Its settled level can be read at any time. For every line, software picks whether a low-to-high transition, a high-to-low transition, both or neither should be recorded.

Recorded transitions collect in a sticky latch. The active-low interrupt pin stays asserted for as long as any latch bit is set. Software reaches the block over a simple single-cycle write port with a combinational read port. Each of the three writable registers (latch, rising-edge enables, falling-edge enables) has two addresses: writing ones to the set address turns bits on, and writing ones to the clear address turns bits off. Zero bits in the written word leave their positions unchanged.

Top module: `otg_irq_latch`

## Requirements
- R1: After a clock edge with `rst_n` low, the latch, the rising-edge enables and the falling-edge enables all read 0, and `irq_n` is 1.
- R2: Address 0 returns the synchronised input levels two clock edges after a change on `stat_in`. Its bit positions are: bit0 VBUS valid, bit1 session valid, bit2 DP high, bit3 ID forced to ground, bit4 DN high, bit5 ID floating, bit6 B-disconnect/A-connect, bit7 car-kit interrupt. Writes to address 0 have no effect.
- R3: A latch bit is set three clock edges after its input goes from 0 to 1, if the bit's rising-edge enable is 1.
- R4: A latch bit is set three clock edges after its input goes from 1 to 0, if the bit's falling-edge enable is 1.
- R5: A transition whose direction is not enabled for that bit leaves the latch unchanged.
- R6: Writing to address 2 clears every latch bit whose data bit is 1 and leaves the others unchanged. Addresses 1 and 2 both read back the latch.
- R7: Writing to address 1 sets every latch bit whose data bit is 1.
- R8: Writes to address 3 set rising-edge enables and writes to address 4 clear them; both addresses read the rising-edge enables. Addresses 5 and 6 do the same for the falling-edge enables.
- R9: If a qualified edge and a clear of the same latch bit fall in the same cycle, the bit ends up set.
- R10: `irq_n` is 0 whenever at least one latch bit is 1, and 1 otherwise.
- R11: Address 7 reads as 0, and writes to it change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| stat_in | input | 8 | Asynchronous status lines from the transceiver detectors |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 3 | Register address for both reads and writes |
| bus_wdata | input | 8 | Write data; a 1 selects the bit to set or clear |
| bus_rdata | output | 8 | Contents of the addressed register, combinational |
| irq_n | output | 1 | Interrupt to the processor, active low |

## Verification
The properties assume that `stat_in` may change at any time, but that each write strobe lasts exactly one cycle with the address and data stable in that cycle. They also assume reset is held for at least one clock edge before any access. The bench drives every input on the falling clock edge, so the synchroniser and the write decode always see settled values. It also keeps transitions on a line at least four cycles apart, so every edge reaches the latch before the next one arrives. The same-cycle edge-and-clear case is produced by timing the clear write to the exact cycle in which the synchronised edge shows up.

// File: rtl/otg_irq_pkg.sv
// Package: shared constants and register address map for the OTG interrupt latch.
// Assumes an 8-bit register file reached through a 3-bit address.
package otg_irq_pkg;

    localparam int unsigned NUM_SRC  = 8;
    localparam int unsigned ADDR_W   = 3;
    localparam int unsigned SYNC_LEN = 2;

    // Register address map; set/clear pairs share one backing register.
    typedef enum logic [ADDR_W-1:0] {
        A_SRC  = 3'd0,
        A_LSET = 3'd1,
        A_LCLR = 3'd2,
        A_RSET = 3'd3,
        A_RCLR = 3'd4,
        A_FSET = 3'd5,
        A_FCLR = 3'd6,
        A_NONE = 3'd7
    } reg_addr_e;

endpackage

// File: rtl/irq_sync_edge.sv
// Module: synchronises asynchronous status lines and reports qualified edges.
// Each bit passes through STAGES flops; one more flop holds the previous
// synchronised value so that rising and falling transitions can be seen.
// Assumes STAGES >= 2 and that inputs are held at least one cycle per level.
module irq_sync_edge #(
    parameter int unsigned W      = 8,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    input  logic [W-1:0] rise_en,
    input  logic [W-1:0] fall_en,
    output logic [W-1:0] level,
    output logic [W-1:0] edge_hit
);

    localparam int unsigned LAST = STAGES - 1;

    logic [W-1:0] chain [STAGES];
    logic [W-1:0] prev_q;
    logic [W-1:0] rose;
    logic [W-1:0] fell;

    // Shift the raw inputs through the synchroniser and keep one delayed copy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) begin
                chain[s] <= '0;
            end
            prev_q <= '0;
        end else begin
            chain[0] <= din;
            for (int s = 1; s < STAGES; s++) begin
                chain[s] <= chain[s-1];
            end
            prev_q <= chain[LAST];
        end
    end

    // Per-bit edge detection, gated by the direction enables.
    for (genvar b = 0; b < W; b++) begin : g_bit
        always_comb begin
            rose[b]     = chain[LAST][b] & ~prev_q[b];
            fell[b]     = ~chain[LAST][b] & prev_q[b];
            edge_hit[b] = (rose[b] & rise_en[b]) | (fell[b] & fall_en[b]);
        end
    end

    assign level = chain[LAST];

endmodule

// File: rtl/irq_setclr_reg.sv
// Module: register with independent write-one-to-set and write-one-to-clear
// inputs. Used for both edge-enable registers. Assumes set and clear never
// arrive in the same cycle; if they did, clear would win.
module irq_setclr_reg #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_vec,
    input  logic [W-1:0] clr_vec,
    output logic [W-1:0] q
);

    // Apply set bits, then clear bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= (q | set_vec) & ~clr_vec;
        end
    end

endmodule

// File: rtl/irq_latch_bank.sv
// Module: sticky interrupt latch. A bit is set by a qualified edge or a
// software set, and cleared by a software clear. In any one cycle an edge
// beats a clear of the same bit, so no event is lost.
module irq_latch_bank #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] edge_hit,
    input  logic [W-1:0] set_vec,
    input  logic [W-1:0] clr_vec,
    output logic [W-1:0] q
);

    logic [W-1:0] clr_eff;

    // A clear takes effect only on bits with no edge in the same cycle.
    assign clr_eff = clr_vec & ~edge_hit;

    // Accumulate events and drop cleared bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= (q | set_vec | edge_hit) & ~clr_eff;
        end
    end

endmodule

// File: rtl/otg_irq_latch.sv
// Module: top of the OTG status interrupt latch. Decodes the register port,
// builds the read mux and drives the active-low interrupt.
// Assumes single-cycle write strobes and a read port sampled combinationally.
module otg_irq_latch
    import otg_irq_pkg::*;
#(
    parameter int unsigned NUM = NUM_SRC
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM-1:0]    stat_in,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [NUM-1:0]    bus_wdata,
    output logic [NUM-1:0]    bus_rdata,
    output logic              irq_n
);

    logic [NUM-1:0] level;
    logic [NUM-1:0] edge_hit;
    logic [NUM-1:0] latch_q;
    logic [NUM-1:0] rise_en;
    logic [NUM-1:0] fall_en;
    logic [NUM-1:0] lset_v, lclr_v, rset_v, rclr_v, fset_v, fclr_v;

    // Write decode: each strobe routes the data word to one set or clear vector.
    always_comb begin
        lset_v = (bus_we && bus_addr == A_LSET) ? bus_wdata : '0;
        lclr_v = (bus_we && bus_addr == A_LCLR) ? bus_wdata : '0;
        rset_v = (bus_we && bus_addr == A_RSET) ? bus_wdata : '0;
        rclr_v = (bus_we && bus_addr == A_RCLR) ? bus_wdata : '0;
        fset_v = (bus_we && bus_addr == A_FSET) ? bus_wdata : '0;
        fclr_v = (bus_we && bus_addr == A_FCLR) ? bus_wdata : '0;
    end

    irq_sync_edge #(.W(NUM), .STAGES(SYNC_LEN)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .din      (stat_in),
        .rise_en  (rise_en),
        .fall_en  (fall_en),
        .level    (level),
        .edge_hit (edge_hit)
    );

    irq_setclr_reg #(.W(NUM)) u_rise (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vec (rset_v),
        .clr_vec (rclr_v),
        .q       (rise_en)
    );

    irq_setclr_reg #(.W(NUM)) u_fall (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vec (fset_v),
        .clr_vec (fclr_v),
        .q       (fall_en)
    );

    irq_latch_bank #(.W(NUM)) u_latch (
        .clk      (clk),
        .rst_n    (rst_n),
        .edge_hit (edge_hit),
        .set_vec  (lset_v),
        .clr_vec  (lclr_v),
        .q        (latch_q)
    );

    // Read mux: both addresses of a pair return the same register.
    always_comb begin
        case (bus_addr)
            A_SRC:          bus_rdata = level;
            A_LSET, A_LCLR: bus_rdata = latch_q;
            A_RSET, A_RCLR: bus_rdata = rise_en;
            A_FSET, A_FCLR: bus_rdata = fall_en;
            default:        bus_rdata = '0;
        endcase
    end

    // Interrupt pin is low while any event is pending.
    assign irq_n = ~(|latch_q);

endmodule

// File: rtl/otg_irq_checker.sv
// Module: property checker for otg_irq_latch, attached with bind below.
// Watches the bus port, the interrupt pin and the internal latch, enable and
// edge vectors.
module otg_irq_checker
    import otg_irq_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [W-1:0]      bus_wdata,
    input logic              irq_n,
    input logic [W-1:0]      latch_q,
    input logic [W-1:0]      rise_en,
    input logic [W-1:0]      fall_en,
    input logic [W-1:0]      edge_hit
);

    logic [W-1:0] set_w;
    logic [W-1:0] clr_w;
    logic         rise_wr;
    logic         fall_wr;

    // Decode the bus on the checker's own terms.
    always_comb begin
        set_w   = (bus_we && bus_addr == A_LSET) ? bus_wdata : '0;
        clr_w   = (bus_we && bus_addr == A_LCLR) ? bus_wdata : '0;
        rise_wr = bus_we && (bus_addr == A_RSET || bus_addr == A_RCLR);
        fall_wr = bus_we && (bus_addr == A_FSET || bus_addr == A_FCLR);
    end

    assert_reset_state_R1: assert property (@(posedge clk)
        !rst_n |=> (latch_q == '0 && rise_en == '0 && fall_en == '0));

    assert_edge_captured_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_hit != '0) |=> ((latch_q & $past(edge_hit)) == $past(edge_hit)));

    assert_no_spurious_latch_R5: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((latch_q & ~$past(latch_q) & ~$past(edge_hit) & ~$past(set_w)) == '0));

    assert_clear_effect_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((clr_w & ~edge_hit) != '0) |=> ((latch_q & $past(clr_w & ~edge_hit)) == '0));

    assert_latch_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(latch_q) & ~$past(clr_w) & ~latch_q) == '0));

    assert_rise_en_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !rise_wr |=> $stable(rise_en));

    assert_fall_en_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !fall_wr |=> $stable(fall_en));

    assert_irq_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_n) |-> ($past(edge_hit | set_w) != '0));

endmodule

bind otg_irq_latch otg_irq_checker #(.W(NUM)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .irq_n     (irq_n),
    .latch_q   (latch_q),
    .rise_en   (rise_en),
    .fall_en   (fall_en),
    .edge_hit  (edge_hit)
);

// File: tb/tb_otg_irq_latch.sv
// Directed bench for otg_irq_latch: one task per scenario, each checking
// its own results at the ports.
module tb_otg_irq_latch;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] stat_in = 8'h00;
    logic       bus_we = 1'b0;
    logic [2:0] bus_addr = 3'd0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       irq_n;

    int n_chk  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    otg_irq_latch dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .stat_in   (stat_in),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_n     (irq_n)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Called just after a falling edge; returns just after the next one.
    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0; bus_wdata = 8'h00;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    // Drive new levels and let them pass the synchroniser and edge stage.
    task automatic drive_stat(input logic [7:0] v);
        stat_in = v;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [7:0] d;
        rd(3'd1, d); check("R1 latch", d, 8'h00);
        rd(3'd3, d); check("R1 rise", d, 8'h00);
        rd(3'd5, d); check("R1 fall", d, 8'h00);
        check("R1 irq_n", {7'd0, irq_n}, 8'h01);
    endtask

    task automatic t_source();
        logic [7:0] d;
        stat_in = 8'hA5;
        @(negedge clk);
        rd(3'd0, d); check("R2 one edge", d, 8'h00);
        @(negedge clk);
        rd(3'd0, d); check("R2 two edges", d, 8'hA5);
        repeat (2) @(negedge clk);
        wr(3'd0, 8'hFF);
        rd(3'd0, d); check("R2 write ignored", d, 8'hA5);
        rd(3'd1, d); check("R5 no enables", d, 8'h00);
    endtask

    task automatic t_masks();
        logic [7:0] d;
        wr(3'd3, 8'h0F); rd(3'd3, d); check("R8 rise set", d, 8'h0F);
        wr(3'd4, 8'h03); rd(3'd4, d); check("R8 rise clr", d, 8'h0C);
        wr(3'd5, 8'hF0); rd(3'd5, d); check("R8 fall set", d, 8'hF0);
        wr(3'd6, 8'h30); rd(3'd6, d); check("R8 fall clr", d, 8'hC0);
    endtask

    task automatic t_rise();
        logic [7:0] d;
        // bit3 rises (enabled), bit4 rises (not enabled)
        stat_in = 8'hBD;
        repeat (2) @(negedge clk);
        rd(3'd1, d); check("R3 before capture", d, 8'h00);
        @(negedge clk);
        rd(3'd1, d); check("R3 R5 rise capture", d, 8'h08);
        check("R10 irq low", {7'd0, irq_n}, 8'h00);
        @(negedge clk);
    endtask

    task automatic t_fall();
        logic [7:0] d;
        // bit7 falls (enabled), bit5 falls (not enabled), bit3 falls (rise only)
        drive_stat(8'h15);
        rd(3'd2, d); check("R4 R5 fall capture", d, 8'h88);
    endtask

    task automatic t_clear();
        logic [7:0] d;
        wr(3'd2, 8'h08); rd(3'd1, d); check("R6 partial clear", d, 8'h80);
        check("R10 irq still low", {7'd0, irq_n}, 8'h00);
        wr(3'd2, 8'h80); rd(3'd1, d); check("R6 full clear", d, 8'h00);
        check("R10 irq released", {7'd0, irq_n}, 8'h01);
    endtask

    task automatic t_set();
        logic [7:0] d;
        wr(3'd1, 8'h21); rd(3'd1, d); check("R7 software set", d, 8'h21);
        check("R7 R10 irq", {7'd0, irq_n}, 8'h00);
        wr(3'd2, 8'hFF); rd(3'd1, d); check("R6 clear all", d, 8'h00);
    endtask

    task automatic t_race();
        logic [7:0] d;
        wr(3'd5, 8'h01);
        wr(3'd1, 8'h01);
        // bit0 falls; the clear lands in the cycle the edge is seen
        stat_in = 8'h14;
        repeat (2) @(negedge clk);
        wr(3'd2, 8'h01);
        rd(3'd1, d); check("R9 edge beats clear", d, 8'h01);
        @(negedge clk);
        wr(3'd2, 8'h01);
        rd(3'd1, d); check("R9 later clear", d, 8'h00);
    endtask

    task automatic t_unmapped();
        logic [7:0] d;
        wr(3'd7, 8'hFF);
        rd(3'd7, d); check("R11 read zero", d, 8'h00);
        rd(3'd1, d); check("R11 latch kept", d, 8'h00);
        rd(3'd3, d); check("R11 rise kept", d, 8'h0C);
        rd(3'd5, d); check("R11 fall kept", d, 8'hC1);
        check("R11 irq idle", {7'd0, irq_n}, 8'h01);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_source();
        t_masks();
        t_rise();
        t_fall();
        t_clear();
        t_set();
        t_race();
        t_unmapped();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        #2000000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule